// File: doc/BRIEF.md
# Binary64 to Unsigned Integer Converter

This unit takes one IEEE-754 double-precision operand and a two-bit rounding selector and produces the unsigned 64-bit integer nearest to it under the selected rounding direction. It also raises two status flags. The invalid flag reports an operand that has no unsigned 64-bit image. The inexact flag reports that rounding discarded a nonzero fraction. Whenever invalid is raised, the result saturates to all ones. The operand is decoded, aligned and rounded in one combinational pass, and the result and flags are registered, so a new operand can be accepted on every clock.

The decoder sorts each operand into one of six classes, and the rounding stage handles each class in its own branch of a unique case:
- ZERO: an exponent field and fraction that are both zero.
- TINY: a subnormal, or a magnitude below one half.
- FRAC: an unbiased exponent from −1 to 51, so the value may have a fractional part.
- WHOLE: an unbiased exponent from 52 to 63, so the value is already an integer.
- HUGE: an unbiased exponent of 64 or more.
- SPECIAL: an all-ones exponent field, which covers NaN and infinity.

The classes are combinational. There are no transitions between them. The only state is the output register, and reset clears it.

Top module: `cvt_f64_u64`

## Requirements
- R1: Result and flags appear on the outputs at the first rising clock edge after the operand and rounding mode are presented. While rst_n is low, all outputs are zero.
- R2: When the value is not an integer, it is rounded using rmode_i. The codes are 00 = nearest with ties to even, 01 = toward minus infinity, 10 = toward plus infinity, 11 = toward zero.
- R3: inexact_o is high exactly when the returned result differs from the exact operand value and invalid_o is low.
- R4: A NaN or an infinity of either sign gives all ones, with invalid_o high and inexact_o low.
- R5: A finite operand with an unbiased exponent of 64 or more gives all ones with invalid_o high.
- R6: An operand with an unbiased exponent from 52 to 63 and a clear sign bit converts exactly, by a left shift of its 53-bit significand, with both flags low.
- R7: A negative operand that rounds to zero gives 0 with invalid_o low. In that case inexact_o is high only if the operand was nonzero.
- R8: A negative operand that rounds to a nonzero magnitude gives all ones with invalid_o high.
- R9: invalid_o and inexact_o are never high together, and invalid_o always comes with an all-ones result.
- R10: A subnormal gives 0 with inexact_o high, unless the rounding direction is away from zero on the operand's side. In that case the magnitude rounds to 1: a positive operand then gives 1, and a negative operand falls under R8.
- R11: Positive and negative zero give 0 with both flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| operand_i | input | 64 | Binary64 operand: sign in bit 63, exponent field in bits 62:52, fraction in bits 51:0 |
| rmode_i | input | 2 | Rounding selector, encoded as in R2 |
| result_o | output | 64 | Unsigned integer result, registered |
| invalid_o | output | 1 | Operand has no unsigned 64-bit image, registered |
| inexact_o | output | 1 | Rounding discarded a nonzero fraction, registered |

## Verification
The assertions take for granted that operand_i and rmode_i are free of unknowns at each rising edge. They also take for granted that one registered cycle separates a stimulus from its response, so every input-based property looks exactly one cycle ahead. The bench drives inputs on the falling edge and holds them through the next rising edge. It spreads random exponents mostly over the window from sub-one-half to just past 64, where the class boundaries lie, and uses all four rounding codes on every class.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_DOWN    = 2'b01,
        RM_UP      = 2'b10,
        RM_ZERO    = 2'b11
    } rmode_e;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_TINY,
        CLS_FRAC,
        CLS_WHOLE,
        CLS_HUGE,
        CLS_SPECIAL
    } op_class_e;

endpackage

// File: rtl/cvt_classify.sv
module cvt_classify
    import cvt_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int INT_W  = 64,
    localparam int FP_W  = EXP_W + FRAC_W + 1,
    localparam int SIG_W = FRAC_W + 1,
    localparam int SH_W  = $clog2(2 * SIG_W)
) (
    input  logic [FP_W-1:0]  operand,
    output op_class_e        cls,
    output logic             sign,
    output logic [SIG_W-1:0] sig,
    output logic [SH_W-1:0]  shr_amt,
    output logic [SH_W-1:0]  shl_amt
);
    localparam int UE_W = EXP_W + 2;
    localparam logic signed [UE_W-1:0] BIAS_S  = UE_W'((1 << (EXP_W - 1)) - 1);
    localparam logic signed [UE_W-1:0] INT_S   = UE_W'(INT_W);
    localparam logic signed [UE_W-1:0] FRAC_S  = UE_W'(FRAC_W);
    localparam logic signed [UE_W-1:0] NEG_ONE = '1;

    logic [EXP_W-1:0]        exp_f;
    logic [FRAC_W-1:0]       frac_f;
    logic signed [UE_W-1:0]  unb_exp;
    logic signed [UE_W-1:0]  diff_r;
    logic signed [UE_W-1:0]  diff_l;

    assign exp_f   = operand[FP_W-2:FRAC_W];
    assign frac_f  = operand[FRAC_W-1:0];
    assign sign    = operand[FP_W-1];
    assign sig     = {(exp_f != '0), frac_f};
    assign unb_exp = $signed({2'b00, exp_f}) - BIAS_S;
    assign diff_r  = FRAC_S - unb_exp;
    assign diff_l  = unb_exp - FRAC_S;
    assign shr_amt = diff_r[SH_W-1:0];
    assign shl_amt = diff_l[SH_W-1:0];

    always_comb begin
        if (&exp_f)
            cls = CLS_SPECIAL;
        else if (exp_f == '0)
            cls = (frac_f == '0) ? CLS_ZERO : CLS_TINY;
        else if (unb_exp >= INT_S)
            cls = CLS_HUGE;
        else if (unb_exp >= FRAC_S)
            cls = CLS_WHOLE;
        else if (unb_exp >= NEG_ONE)
            cls = CLS_FRAC;
        else
            cls = CLS_TINY;
    end

endmodule

// File: rtl/cvt_align.sv
module cvt_align
    import cvt_pkg::*;
#(
    parameter int FRAC_W = 52,
    parameter int INT_W  = 64,
    localparam int SIG_W = FRAC_W + 1,
    localparam int SH_W  = $clog2(2 * SIG_W)
) (
    input  op_class_e        cls,
    input  logic [SIG_W-1:0] sig,
    input  logic [SH_W-1:0]  shr_amt,
    input  logic [SH_W-1:0]  shl_amt,
    output logic [INT_W-1:0] int_part,
    output logic             guard,
    output logic             sticky
);
    localparam int PAD_W = INT_W - SIG_W;

    logic [2*SIG_W-1:0] wide;
    logic [INT_W-1:0]   int_frac;
    logic [INT_W-1:0]   int_whole;

    assign wide      = {sig, {SIG_W{1'b0}}} >> shr_amt;
    assign int_frac  = {{PAD_W{1'b0}}, wide[2*SIG_W-1:SIG_W]};
    assign int_whole = {{PAD_W{1'b0}}, sig} << shl_amt;

    always_comb begin
        unique case (cls)
            CLS_FRAC: begin
                int_part = int_frac;
                guard    = wide[SIG_W-1];
                sticky   = |wide[SIG_W-2:0];
            end
            CLS_TINY: begin
                int_part = '0;
                guard    = 1'b0;
                sticky   = 1'b1;
            end
            CLS_WHOLE: begin
                int_part = int_whole;
                guard    = 1'b0;
                sticky   = 1'b0;
            end
            default: begin
                int_part = '0;
                guard    = 1'b0;
                sticky   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cvt_round.sv
module cvt_round
    import cvt_pkg::*;
#(
    parameter int INT_W = 64
) (
    input  op_class_e        cls,
    input  logic             sign,
    input  logic [1:0]       rmode,
    input  logic [INT_W-1:0] int_part,
    input  logic             guard,
    input  logic             sticky,
    output logic [INT_W-1:0] result,
    output logic             invalid,
    output logic             inexact
);
    logic             lost;
    logic             bump;
    logic [INT_W-1:0] mag;

    assign lost = guard | sticky;

    always_comb begin
        unique case (rmode_e'(rmode))
            RM_NEAREST: bump = guard & (sticky | int_part[0]);
            RM_DOWN:    bump = sign & lost;
            RM_UP:      bump = ~sign & lost;
            RM_ZERO:    bump = 1'b0;
            default:    bump = 1'b0;
        endcase
    end

    assign mag = int_part + INT_W'(bump);

    always_comb begin
        result  = '0;
        invalid = 1'b0;
        inexact = 1'b0;
        unique case (cls)
            CLS_ZERO: begin
                result = '0;
            end
            CLS_TINY, CLS_FRAC: begin
                if (sign && mag != '0) begin
                    result  = '1;
                    invalid = 1'b1;
                end else begin
                    result  = mag;
                    inexact = lost;
                end
            end
            CLS_WHOLE: begin
                if (sign) begin
                    result  = '1;
                    invalid = 1'b1;
                end else begin
                    result = int_part;
                end
            end
            CLS_HUGE, CLS_SPECIAL: begin
                result  = '1;
                invalid = 1'b1;
            end
            default: begin
                result = '0;
            end
        endcase
    end

endmodule

// File: rtl/cvt_f64_u64.sv
module cvt_f64_u64
    import cvt_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int INT_W  = 64,
    localparam int FP_W  = EXP_W + FRAC_W + 1,
    localparam int SIG_W = FRAC_W + 1,
    localparam int SH_W  = $clog2(2 * SIG_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FP_W-1:0]  operand_i,
    input  logic [1:0]       rmode_i,
    output logic [INT_W-1:0] result_o,
    output logic             invalid_o,
    output logic             inexact_o
);
    op_class_e        cls;
    logic             sign;
    logic [SIG_W-1:0] sig;
    logic [SH_W-1:0]  shr_amt;
    logic [SH_W-1:0]  shl_amt;
    logic [INT_W-1:0] int_part;
    logic             guard;
    logic             sticky;
    logic [INT_W-1:0] result_d;
    logic             invalid_d;
    logic             inexact_d;

    cvt_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_classify (
        .operand (operand_i),
        .cls     (cls),
        .sign    (sign),
        .sig     (sig),
        .shr_amt (shr_amt),
        .shl_amt (shl_amt)
    );

    cvt_align #(.FRAC_W(FRAC_W), .INT_W(INT_W)) u_align (
        .cls      (cls),
        .sig      (sig),
        .shr_amt  (shr_amt),
        .shl_amt  (shl_amt),
        .int_part (int_part),
        .guard    (guard),
        .sticky   (sticky)
    );

    cvt_round #(.INT_W(INT_W)) u_round (
        .cls      (cls),
        .sign     (sign),
        .rmode    (rmode_i),
        .int_part (int_part),
        .guard    (guard),
        .sticky   (sticky),
        .result   (result_d),
        .invalid  (invalid_d),
        .inexact  (inexact_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o  <= '0;
            invalid_o <= 1'b0;
            inexact_o <= 1'b0;
        end else begin
            result_o  <= result_d;
            invalid_o <= invalid_d;
            inexact_o <= inexact_d;
        end
    end

endmodule

// File: rtl/cvt_f64_u64_chk.sv
module cvt_f64_u64_chk #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int INT_W  = 64,
    localparam int FP_W  = EXP_W + FRAC_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [FP_W-1:0]  operand_i,
    input logic [1:0]       rmode_i,
    input logic [INT_W-1:0] result_o,
    input logic             invalid_o,
    input logic             inexact_o
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam logic [EXP_W-1:0] HUGE_E  = EXP_W'(BIAS + INT_W);
    localparam logic [EXP_W-1:0] WHOLE_E = EXP_W'(BIAS + FRAC_W);
    localparam logic [EXP_W-1:0] TOP_E   = EXP_W'(BIAS + INT_W - 1);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    assign exp_f  = operand_i[FP_W-2:FRAC_W];
    assign frac_f = operand_i[FRAC_W-1:0];

    // R9
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |-> !inexact_o);

    // R9
    sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |-> (&result_o));

    // R4
    special_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&exp_f) |=> (invalid_o && !inexact_o));

    // R5
    huge_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_f >= HUGE_E && !(&exp_f)) |=> invalid_o);

    // R6
    whole_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!operand_i[FP_W-1] && exp_f >= WHOLE_E && exp_f <= TOP_E)
            |=> (!invalid_o && !inexact_o));

    // R11
    zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (operand_i[FP_W-2:0] == '0) |=> (result_o == '0 && !invalid_o && !inexact_o));

    // R7
    neg_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        operand_i[FP_W-1] |=> (result_o == '0 || invalid_o));

    // R10
    denorm_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_f == '0 && frac_f != '0 && rmode_i == 2'b11)
            |=> (result_o == '0 && inexact_o && !invalid_o));

endmodule

bind cvt_f64_u64 cvt_f64_u64_chk #(
    .EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .operand_i (operand_i),
    .rmode_i   (rmode_i),
    .result_o  (result_o),
    .invalid_o (invalid_o),
    .inexact_o (inexact_o)
);

// File: tb/cvt_f64_u64_test.sv
module cvt_f64_u64_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] operand_i = '0;
    logic [1:0]  rmode_i = 2'b00;
    logic [63:0] result_o;
    logic        invalid_o;
    logic        inexact_o;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cvt_f64_u64 uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .operand_i (operand_i),
        .rmode_i   (rmode_i),
        .result_o  (result_o),
        .invalid_o (invalid_o),
        .inexact_o (inexact_o)
    );

    // Fixed-point reference: value scaled by 2^128 in a 256-bit word.
    function automatic void ref_model(input logic [63:0] op, input logic [1:0] rm,
                                      output logic [63:0] r, output logic inv,
                                      output logic inx);
        logic         s;
        logic [10:0]  ef;
        logic [51:0]  ff;
        logic [52:0]  sg;
        int           e;
        logic [255:0] fx;
        logic [127:0] fl;
        logic [127:0] fr;
        logic         nz, above, tie, up;
        logic [127:0] mag;
        s  = op[63];
        ef = op[62:52];
        ff = op[51:0];
        r = '0; inv = 1'b0; inx = 1'b0;
        if (ef == 11'h7FF) begin
            r = '1; inv = 1'b1; return;
        end
        if (ef == 0 && ff == 0) return;
        if (ef == 0) begin
            sg = {1'b0, ff}; e = -1022;
        end else begin
            sg = {1'b1, ff}; e = int'(ef) - 1023;
        end
        if (e >= 64) begin
            r = '1; inv = 1'b1; return;
        end
        if (e < -70) begin
            fl = '0; nz = 1'b1; above = 1'b0; tie = 1'b0;
        end else begin
            fx = {203'b0, sg} << (e + 76);
            fl = fx[255:128];
            fr = fx[127:0];
            nz = (fr != 0);
            above = (fr > {1'b1, 127'b0});
            tie = (fr == {1'b1, 127'b0});
        end
        case (rm)
            2'b00: up = above | (tie & fl[0]);
            2'b01: up = s & nz;
            2'b10: up = !s & nz;
            default: up = 1'b0;
        endcase
        mag = fl + 128'(up);
        if (mag == 0) begin
            r = '0; inx = nz;
        end else if (s || mag[127:64] != 0) begin
            r = '1; inv = 1'b1;
        end else begin
            r = mag[63:0]; inx = nz;
        end
    endfunction

    task automatic check(input string req, input logic [63:0] er,
                         input logic ei, input logic ex);
        compared++;
        if (result_o !== er || invalid_o !== ei || inexact_o !== ex) begin
            mismatched++;
            $display("FAIL %s op=%h rm=%b: got %h inv=%b inx=%b, expected %h inv=%b inx=%b",
                     req, operand_i, rmode_i, result_o, invalid_o, inexact_o, er, ei, ex);
        end
    endtask

    task automatic apply(input logic [63:0] op, input logic [1:0] rm, input string req);
        logic [63:0] er;
        logic        ei, ex;
        @(negedge clk);
        operand_i = op;
        rmode_i   = rm;
        ref_model(op, rm, er, ei, ex);
        @(negedge clk);
        check(req, er, ei, ex);
    endtask

    initial begin
        logic [63:0] op;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", 64'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
        // R1: output holds until the next rising edge
        @(negedge clk);
        operand_i = 64'h4014000000000000;
        rmode_i = 2'b00;
        #2 check("R1", 64'h0, 1'b0, 1'b0);
        @(negedge clk);
        check("R1", 64'd5, 1'b0, 1'b0);

        // R2 / R3: 2.5, 3.5, 0.5 and 1.5 under each direction
        for (int m = 0; m < 4; m++) begin
            apply(64'h4004000000000000, 2'(m), "R2");
            apply(64'h400C000000000000, 2'(m), "R2");
            apply(64'h3FE0000000000000, 2'(m), "R3");
            apply(64'h3FF8000000000000, 2'(m), "R2");
            apply(64'h4320000000000001, 2'(m), "R2");
        end
        apply(64'h4024000000000000, 2'b00, "R3");
        apply(64'h7FF0000000000000, 2'b00, "R4");
        apply(64'hFFF0000000000000, 2'b10, "R4");
        apply(64'h7FF8000000000000, 2'b01, "R4");
        apply(64'h7FF0000000000001, 2'b11, "R4");
        apply(64'h43F0000000000000, 2'b00, "R5");
        apply(64'hC3F0000000000000, 2'b10, "R5");
        apply(64'h43E0000000000000, 2'b00, "R6");
        apply(64'h43EFFFFFFFFFFFFF, 2'b11, "R6");
        apply(64'h4330000000000000, 2'b01, "R6");
        apply(64'hBFD3333333333333, 2'b00, "R7");
        apply(64'hBFD3333333333333, 2'b10, "R7");
        apply(64'hBFD3333333333333, 2'b01, "R8");
        apply(64'hBFE6666666666666, 2'b00, "R8");
        apply(64'hC024000000000000, 2'b11, "R8");
        apply(64'h0000000000000001, 2'b00, "R10");
        apply(64'h0000000000000001, 2'b10, "R10");
        apply(64'h000FFFFFFFFFFFFF, 2'b11, "R10");
        apply(64'h8000000000000001, 2'b10, "R10");
        apply(64'h8000000000000001, 2'b01, "R10");
        apply(64'h0000000000000000, 2'b10, "R11");
        apply(64'h8000000000000000, 2'b01, "R11");
        apply(64'h43EFFFFFFFFFFFFF, 2'b00, "R9");
        apply(64'hC3EFFFFFFFFFFFFF, 2'b00, "R9");

        for (int i = 0; i < 3000; i++) begin
            logic [10:0] ef;
            op = {$urandom, $urandom};
            if ($urandom_range(0, 9) < 8)
                ef = 11'(1023 - 4 + $urandom_range(0, 72));
            else
                ef = 11'($urandom);
            op[62:52] = ef;
            if ($urandom_range(0, 3) == 0) op[51:0] = op[51:0] & 52'hF_0000_0000_0000;
            apply(op, 2'($urandom), "R2");
        end

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL R1 watchdog: got no completion, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule